// File: doc/BRIEF.md
# Channel-Aware Audio Sample FIFO

This block is a word FIFO that sits between a register-side producer and the serial shifter that sends samples out (the same storage also serves capture, with the roles of the two ports swapped). Samples are interleaved by channel. The storage is sized as a base of 256 words shifted left by a static size code. Channels are kept in power-of-two groups, so the number of frames the FIFO can hold is the capacity divided by the channel count rounded up to a power of two. With 256 words, three channels get 64 frames and six channels get 32.

The status word reports the fill level in whole frames, not in words. It also holds two sticky error flags, one for a push into a full FIFO and one for a pop from an empty FIFO. A control write can empty the FIFO in a single cycle and can enable an interrupt request. That request is raised when the frame level crosses half of the frame capacity.

Top module: `chan_sample_fifo`

## Requirements
- R1: After reset the status word reads zero, `irq_o` is low and a pop returns zero.
- R2: With an effective channel count C (0 is taken as 1, above 8 as 8), let G be C rounded up to a power of two (1, 2, 4 or 8). The FIFO accepts exactly (capacity / G) × C words before it refuses pushes.
- R3: A push when the FIFO is full drops the word and sets the sticky overrun flag at status bit 4.
- R4: A pop when the FIFO is empty leaves the contents unchanged, returns zero on `pop_data_o` and sets the sticky underrun flag at status bit 0.
- R5: Words leave in the order they were pushed. `pop_data_o` shows the oldest word in the same cycle as the pop.
- R6: Status bits [16:8] hold the level in frames. It rises by one when a push fills the last channel of a frame. It falls by one when a pop removes the last channel of a frame.
- R7: A status write clears each error flag whose bit is written 0 and keeps the flag whose bit is written 1. Events in the same cycle still set their flag. Any status write drops the pending half-level request.
- R8: A control write with bit 0 set empties the FIFO and zeroes the frame level in one cycle. The bit self-clears. A push or pop in that cycle is ignored and sets no error flag. The error flags are not changed.
- R9: A request becomes pending whenever the frame level moves across half the frame capacity, in either direction. `irq_o` is pending AND the enable stored from control bit 20. A clear drops the pending request.
- R10: When a push and a pop fall in the same cycle, both act. Whether the push is accepted depends on the word count before that cycle, so a push at full is dropped even when a pop frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| chan_cnt_i | input | 4 | Channels per frame (1 to 8); changed only while empty |
| push_i | input | 1 | Push one word |
| push_data_i | input | WORD_W | Word to push |
| pop_i | input | 1 | Pop one word |
| pop_data_o | output | WORD_W | Oldest word, zero when empty |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 32 | Control data: bit 0 clear, bit 20 half-level request enable |
| sts_we_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 32 | Status write data: bit 4 and bit 0 written 0 clear the flags |
| status_o | output | 32 | [16:8] frame level, [4] overrun, [0] underrun |
| irq_o | output | 1 | Half-level interrupt request |

## Verification
Two pairs of functions can meet in a single cycle: a push and a pop, and a status write and a new error event. Directed steps push and pop together on a full FIFO, and clear the FIFO while a push is offered. Random stimulus with a fixed seed mixes pushes, pops, status writes and rare clears. It overlaps every pair many times while channel counts change after each clear. Each case is judged by a bench model built from the requirements. The model applies the status write to the old flags before the new events, and decides push acceptance from the word count before the cycle.

// File: rtl/chfifo_pkg.sv
`timescale 1ns/1ps
package chfifo_pkg;
    localparam int CTL_CLR_BIT  = 0;
    localparam int CTL_HALF_BIT = 20;
    localparam int ST_UNR_BIT   = 0;
    localparam int ST_OVR_BIT   = 4;
    localparam int ST_LVL_LSB   = 8;
    localparam int ST_LVL_W     = 9;
    localparam int MAX_CHAN     = 8;

    // clamp the requested channel count to 1..MAX_CHAN
    function automatic logic [3:0] eff_chan(input logic [3:0] ch);
        if (ch == 4'd0)
            return 4'd1;
        else if (ch > 4'(MAX_CHAN))
            return 4'(MAX_CHAN);
        else
            return ch;
    endfunction

    // log2 of the power-of-two group that holds one frame
    function automatic logic [1:0] grp_shift(input logic [3:0] ch);
        if (ch <= 4'd1)
            return 2'd0;
        else if (ch == 4'd2)
            return 2'd1;
        else if (ch <= 4'd4)
            return 2'd2;
        else
            return 2'd3;
    endfunction
endpackage

// File: rtl/chfifo_geom.sv
`timescale 1ns/1ps
module chfifo_geom
    import chfifo_pkg::*;
#(
    parameter int CAP_WORDS = 256,
    parameter int CNT_W     = 9
) (
    input  logic [3:0]       chan_i,
    output logic [3:0]       eff_chan_o,
    output logic [CNT_W-1:0] frame_cap_o,
    output logic [CNT_W-1:0] word_cap_o,
    output logic [CNT_W-1:0] half_lvl_o
);
    localparam int PROD_W = CNT_W + 4;

    logic [1:0]        shift;
    logic [PROD_W-1:0] prod;

    always_comb begin
        eff_chan_o  = eff_chan(chan_i);
        shift       = grp_shift(eff_chan_o);
        frame_cap_o = CNT_W'(CAP_WORDS) >> shift;
        prod        = PROD_W'(frame_cap_o) * PROD_W'(eff_chan_o);
        word_cap_o  = prod[CNT_W-1:0];
        half_lvl_o  = frame_cap_o >> 1;
    end
endmodule

// File: rtl/chfifo_store.sv
`timescale 1ns/1ps
module chfifo_store #(
    parameter int W     = 24,
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i)
            mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/chan_sample_fifo.sv
`timescale 1ns/1ps
module chan_sample_fifo
    import chfifo_pkg::*;
#(
    parameter int WORD_W     = 24,
    parameter int BASE_WORDS = 256,
    parameter int SIZE_CODE  = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [3:0]        chan_cnt_i,
    input  logic              push_i,
    input  logic [WORD_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [WORD_W-1:0] pop_data_o,
    input  logic              ctl_we_i,
    input  logic [31:0]       ctl_wdata_i,
    input  logic              sts_we_i,
    input  logic [31:0]       sts_wdata_i,
    output logic [31:0]       status_o,
    output logic              irq_o
);
    localparam int CAP   = BASE_WORDS << SIZE_CODE;
    localparam int AW    = $clog2(CAP);
    localparam int CNT_W = $clog2(CAP + 1);
    localparam int CH_W  = $clog2(MAX_CHAN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    wr_ptr;
        logic [AW-1:0]    rd_ptr;
        logic [CH_W-1:0]  wr_ch;
        logic [CH_W-1:0]  rd_ch;
        logic [CNT_W-1:0] level;
        logic             ovr;
        logic             unr;
        logic             pend;
        logic             half_en;
    } fifo_st_t;

    fifo_st_t st_q, st_d;

    logic [3:0]        eff_ch;
    logic [CNT_W-1:0]  frame_cap, word_cap, half_lvl, cnt_obs;
    logic [WORD_W-1:0] head;
    logic              clr, push_ok, pop_ok, ovr_evt, unr_evt;
    logic              wr_last, rd_last, crossed, full, empty;
    logic [3:0]        last_idx;

    chfifo_geom #(.CAP_WORDS(CAP), .CNT_W(CNT_W)) i_geom (
        .chan_i      (chan_cnt_i),
        .eff_chan_o  (eff_ch),
        .frame_cap_o (frame_cap),
        .word_cap_o  (word_cap),
        .half_lvl_o  (half_lvl)
    );

    chfifo_store #(.W(WORD_W), .DEPTH(CAP), .AW(AW)) i_store (
        .clk_i   (clk_i),
        .we_i    (push_ok),
        .waddr_i (st_q.wr_ptr),
        .wdata_i (push_data_i),
        .raddr_i (st_q.rd_ptr),
        .rdata_o (head)
    );

    always_comb begin
        st_d     = st_q;
        clr      = ctl_we_i && ctl_wdata_i[CTL_CLR_BIT];
        full     = st_q.cnt >= word_cap;
        empty    = st_q.cnt == '0;
        push_ok  = push_i && !full && !clr;
        pop_ok   = pop_i && !empty && !clr;
        ovr_evt  = push_i && full && !clr;
        unr_evt  = pop_i && empty && !clr;
        last_idx = eff_ch - 4'd1;
        wr_last  = ({1'b0, st_q.wr_ch} == last_idx);
        rd_last  = ({1'b0, st_q.rd_ch} == last_idx);

        if (ctl_we_i)
            st_d.half_en = ctl_wdata_i[CTL_HALF_BIT];

        if (push_ok) begin
            st_d.wr_ptr = st_q.wr_ptr + 1'b1;
            st_d.wr_ch  = wr_last ? '0 : st_q.wr_ch + 1'b1;
        end
        if (pop_ok) begin
            st_d.rd_ptr = st_q.rd_ptr + 1'b1;
            st_d.rd_ch  = rd_last ? '0 : st_q.rd_ch + 1'b1;
        end

        st_d.cnt   = st_q.cnt + {{(CNT_W-1){1'b0}}, push_ok}
                              - {{(CNT_W-1){1'b0}}, pop_ok};
        st_d.level = st_q.level + {{(CNT_W-1){1'b0}}, push_ok && wr_last}
                                - {{(CNT_W-1){1'b0}}, pop_ok && rd_last};
        crossed    = (st_q.level >= half_lvl) != (st_d.level >= half_lvl);

        st_d.ovr  = (sts_we_i ? (st_q.ovr & sts_wdata_i[ST_OVR_BIT]) : st_q.ovr) | ovr_evt;
        st_d.unr  = (sts_we_i ? (st_q.unr & sts_wdata_i[ST_UNR_BIT]) : st_q.unr) | unr_evt;
        st_d.pend = (sts_we_i ? 1'b0 : st_q.pend) | crossed;

        if (clr) begin
            st_d.cnt    = '0;
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.wr_ch  = '0;
            st_d.rd_ch  = '0;
            st_d.level  = '0;
            st_d.pend   = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    logic [ST_LVL_W-1:0] lvl_field;
    if (CNT_W >= ST_LVL_W) begin : g_lvl_trunc
        assign lvl_field = st_q.level[ST_LVL_W-1:0];
    end else begin : g_lvl_pad
        assign lvl_field = {{(ST_LVL_W-CNT_W){1'b0}}, st_q.level};
    end

    assign cnt_obs    = st_q.cnt;
    assign pop_data_o = (st_q.cnt == '0) ? '0 : head;
    assign status_o   = {15'd0, lvl_field, 3'd0, st_q.ovr, 3'd0, st_q.unr};
    assign irq_o      = st_q.pend & st_q.half_en;
endmodule

// File: rtl/chfifo_chk.sv
`timescale 1ns/1ps
module chfifo_chk #(
    parameter int CNT_W  = 9,
    parameter int WORD_W = 24
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              pop_i,
    input logic [WORD_W-1:0] pop_data_o,
    input logic              ctl_we_i,
    input logic [31:0]       ctl_wdata_i,
    input logic              sts_we_i,
    input logic [31:0]       status_o,
    input logic              irq_o,
    input logic [CNT_W-1:0]  cnt_i,
    input logic [CNT_W-1:0]  word_cap_i
);
    // R2
    cap_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_i <= word_cap_i);

    // R3
    ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[4] && !sts_we_i) |=> status_o[4]);

    // R4
    empty_pop_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && cnt_i == '0) |-> pop_data_o == '0);

    // R6
    level_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ctl_we_i && ctl_wdata_i[0]) |=>
            (({1'b0, $past(status_o[16:8])} + 10'd1) >= {1'b0, status_o[16:8]}) &&
            (({1'b0, status_o[16:8]} + 10'd1) >= {1'b0, $past(status_o[16:8])}));

    // R8
    clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_we_i && ctl_wdata_i[0]) |=> (cnt_i == '0 && status_o[16:8] == 9'd0));

    // R9
    irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_we_i && !ctl_wdata_i[20]) |=> !irq_o);
endmodule

bind chan_sample_fifo chfifo_chk #(.CNT_W(CNT_W), .WORD_W(WORD_W)) i_chfifo_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_i       (pop_i),
    .pop_data_o  (pop_data_o),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (ctl_wdata_i),
    .sts_we_i    (sts_we_i),
    .status_o    (status_o),
    .irq_o       (irq_o),
    .cnt_i       (cnt_obs),
    .word_cap_i  (word_cap)
);

// File: tb/test_chan_sample_fifo.sv
`timescale 1ns/1ps
module test_chan_sample_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int CAPW       = 256;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [3:0]  chan_cnt_i = 4'd1;
    logic        push_i = 1'b0;
    logic [23:0] push_data_i = '0;
    logic        pop_i = 1'b0;
    logic [23:0] pop_data_o;
    logic        ctl_we_i = 1'b0;
    logic [31:0] ctl_wdata_i = '0;
    logic        sts_we_i = 1'b0;
    logic [31:0] sts_wdata_i = '0;
    logic [31:0] status_o;
    logic        irq_o;

    chan_sample_fifo i_chan_sample_fifo (
        .clk_i(clk_i), .rst_ni(rst_ni), .chan_cnt_i(chan_cnt_i),
        .push_i(push_i), .push_data_i(push_data_i), .pop_i(pop_i),
        .pop_data_o(pop_data_o), .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
        .sts_we_i(sts_we_i), .sts_wdata_i(sts_wdata_i), .status_o(status_o),
        .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench model, built from the requirements
    logic [23:0] mq[$];
    int  m_chan = 1;
    int  m_wch = 0, m_rch = 0, m_lvl = 0;
    bit  m_ovr = 0, m_unr = 0, m_pend = 0, m_en = 0;

    function automatic int f_eff(int ch);
        return (ch == 0) ? 1 : ((ch > 8) ? 8 : ch);
    endfunction
    function automatic int f_grp(int ch);
        int e = f_eff(ch);
        return (e <= 1) ? 1 : (e == 2) ? 2 : (e <= 4) ? 4 : 8;
    endfunction
    function automatic int f_fcap(int ch);
        return CAPW / f_grp(ch);
    endfunction
    function automatic int f_wcap(int ch);
        return f_fcap(ch) * f_eff(ch);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(bit pu, logic [23:0] d, bit po, bit cwe, logic [31:0] cw,
                        bit swe, logic [31:0] sw);
        int oc, half, old_lvl, e;
        logic [23:0] exp_d;
        @(negedge clk_i);
        chk(status_o[16:8] == 9'(m_lvl), "R6 level", int'(status_o[16:8]), m_lvl);
        chk(status_o[4] == m_ovr, "R3 overrun", int'(status_o[4]), int'(m_ovr));
        chk(status_o[0] == m_unr, "R4 underrun", int'(status_o[0]), int'(m_unr));
        chk(irq_o == (m_en && m_pend), "R9 irq", int'(irq_o), int'(m_en && m_pend));
        push_i = pu; push_data_i = d; pop_i = po;
        ctl_we_i = cwe; ctl_wdata_i = cw; sts_we_i = swe; sts_wdata_i = sw;
        #1;
        if (po) begin
            exp_d = (mq.size() > 0) ? mq[0] : 24'd0;
            chk(pop_data_o == exp_d, "R5 pop data", int'(pop_data_o), int'(exp_d));
        end
        @(posedge clk_i);
        e = f_eff(m_chan);
        half = f_fcap(m_chan) / 2;
        old_lvl = m_lvl;
        if (cwe) m_en = cw[20];
        if (swe) begin
            m_ovr = m_ovr & sw[4];
            m_unr = m_unr & sw[0];
            m_pend = 0;
        end
        if (cwe && cw[0]) begin
            mq.delete();
            m_wch = 0; m_rch = 0; m_lvl = 0; m_pend = 0;
        end else begin
            oc = mq.size();
            if (po) begin
                if (oc > 0) begin
                    void'(mq.pop_front());
                    if (m_rch == e - 1) begin m_rch = 0; m_lvl--; end
                    else m_rch++;
                end else m_unr = 1;
            end
            if (pu) begin
                if (oc < f_wcap(m_chan)) begin
                    mq.push_back(d);
                    if (m_wch == e - 1) begin m_wch = 0; m_lvl++; end
                    else m_wch++;
                end else m_ovr = 1;
            end
            if ((old_lvl >= half) != (m_lvl >= half)) m_pend = 1;
        end
        #1;
        push_i = 0; pop_i = 0; ctl_we_i = 0; sts_we_i = 0;
    endtask

    task automatic idle();
        step(0, 24'd0, 0, 0, 32'd0, 0, 32'd0);
    endtask
    task automatic do_push(logic [23:0] d);
        step(1, d, 0, 0, 32'd0, 0, 32'd0);
    endtask
    task automatic do_pop();
        step(0, 24'd0, 1, 0, 32'd0, 0, 32'd0);
    endtask
    task automatic do_clear(bit en);
        step(0, 24'd0, 0, 1, {11'd0, en, 19'd0, 1'b1}, 0, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            n_fail++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        // R1 reset state
        chk(status_o == 32'd0, "R1 status", int'(status_o), 0);
        chk(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);
        chk(pop_data_o == 24'd0, "R1 pop data", int'(pop_data_o), 0);

        // one channel, enable half-level request
        step(0, 24'd0, 0, 1, 32'h0010_0000, 0, 32'd0);
        for (int i = 0; i < 127; i++) do_push(24'h100 + 24'(i));
        @(negedge clk_i);
        chk(irq_o == 1'b0, "R9 below half", int'(irq_o), 0);
        do_push(24'h17F);
        @(negedge clk_i);
        chk(irq_o == 1'b1, "R9 crossing half", int'(irq_o), 1);
        step(0, 24'd0, 0, 0, 32'd0, 1, 32'h11);
        @(negedge clk_i);
        chk(irq_o == 1'b0, "R7 status write drops request", int'(irq_o), 0);
        for (int i = 128; i < 256; i++) do_push(24'h100 + 24'(i));
        @(negedge clk_i);
        chk(status_o[16:8] == 9'd256, "R2 one channel frames", int'(status_o[16:8]), 256);
        chk(status_o[4] == 1'b0, "R2 no overrun at capacity", int'(status_o[4]), 0);
        do_push(24'hBAD);
        @(negedge clk_i);
        chk(status_o[4] == 1'b1, "R3 push at full", int'(status_o[4]), 1);
        step(0, 24'd0, 0, 0, 32'd0, 1, 32'h01);
        @(negedge clk_i);
        chk(status_o[4] == 1'b0, "R7 overrun cleared", int'(status_o[4]), 0);
        // R10 push and pop together while full
        step(1, 24'hCAFE, 1, 0, 32'd0, 0, 32'd0);
        @(negedge clk_i);
        chk(status_o[16:8] == 9'd255, "R10 pop acts at full", int'(status_o[16:8]), 255);
        chk(status_o[4] == 1'b1, "R10 push judged on old count", int'(status_o[4]), 1);
        for (int i = 0; i < 255; i++) do_pop();
        do_pop();
        @(negedge clk_i);
        chk(status_o[0] == 1'b1, "R4 pop on empty", int'(status_o[0]), 1);
        step(0, 24'd0, 0, 0, 32'd0, 1, 32'h10);
        @(negedge clk_i);
        chk(status_o[4:0] == 5'h10, "R7 selective clear", int'(status_o[4:0]), 16);
        step(0, 24'd0, 0, 0, 32'd0, 1, 32'h00);

        // three channels
        chan_cnt_i = 4'd3; m_chan = 3;
        for (int i = 0; i < 10; i++) do_push(24'h300 + 24'(i));
        @(negedge clk_i);
        chk(status_o[16:8] == 9'd3, "R6 partial frame not counted", int'(status_o[16:8]), 3);
        step(1, 24'h999, 1, 1, 32'h1, 0, 32'd0);
        @(negedge clk_i);
        chk(status_o == 32'd0, "R8 clear empties, no flags", int'(status_o), 0);
        do_pop();
        @(negedge clk_i);
        chk(status_o[0] == 1'b1, "R8 empty after clear", int'(status_o[0]), 1);
        for (int i = 0; i < 193; i++) do_push(24'h400 + 24'(i));
        @(negedge clk_i);
        chk(status_o[16:8] == 9'd64, "R2 three channel frames", int'(status_o[16:8]), 64);
        chk(status_o[4] == 1'b1, "R2 overrun past 192 words", int'(status_o[4]), 1);
        chk(status_o[0] == 1'b1, "R8 clear keeps flags", int'(status_o[0]), 1);

        // five channels
        do_clear(1'b0);
        step(0, 24'd0, 0, 0, 32'd0, 1, 32'h0);
        chan_cnt_i = 4'd5; m_chan = 5;
        for (int i = 0; i < 161; i++) do_push(24'h500 + 24'(i));
        @(negedge clk_i);
        chk(status_o[16:8] == 9'd32, "R2 five channel frames", int'(status_o[16:8]), 32);
        chk(status_o[4] == 1'b1, "R2 overrun past 160 words", int'(status_o[4]), 1);

        // random mix
        do_clear(1'b1);
        chan_cnt_i = 4'd2; m_chan = 2;
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 199);
            bit pu = $urandom_range(0, 99) < 55;
            bit po = $urandom_range(0, 99) < 45;
            bit cwe = (r < 3);
            bit en = $urandom_range(0, 3) != 0;
            logic [31:0] cw = {11'd0, en, 19'd0, (r == 0)};
            bit swe = (r >= 3 && r < 9);
            logic [31:0] sw = $urandom & 32'h11;
            step(pu, 24'($urandom), po, cwe, cw, swe, sw);
            if (cwe && cw[0]) begin
                m_chan = $urandom_range(1, 8);
                chan_cnt_i = 4'(m_chan);
            end
        end
        idle();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule